// File: doc/BRIEF.md
# Multidrop Serial Transmitter with Address Flag

This block sends asynchronous serial frames onto a shared multidrop line. Each frame carries, after its eight data bits, one extra flag bit that marks it as an address (ID) frame or a data frame. Receivers use this flag to tell address frames from data frames. A one-byte holding register sits in front of the shift register. Software can therefore load the next byte while the current frame is still on the line, and frames go out back to back.

Software writes a byte with a strobe. It then clears the empty flag to say that the byte is valid. The transmitter moves the byte into its shifter when it is enabled and free. At that moment it samples the address-flag input and sets the empty flag again. If the last stop bit ends while no new byte is waiting, the end flag sets. Each flag drives its own level interrupt request, and each request has its own enable. An external tick stands in for the baud-rate generator. One bit on the line lasts a fixed number of ticks.

Top module: `mptx_top`

## Requirements
- R1: When no frame is being shifted, `txd_o` is 1 (mark).
- R2: A frame is, in time order: a start bit of 0, then data bits D0 first through D7, then the flag bit, then a stop bit of 1. Each bit lasts TICKS_PER_BIT (16) pulses of `tick_i`, counted from the cycle after the transfer.
- R3: The flag bit of a frame equals `mpb_i` in the transfer cycle: 1 marks an ID frame and 0 a data frame.
- R4: A transfer happens in a cycle where `tx_en_i` is 1, `empty_o` is 0, and the shifter is idle or finishing its stop bit. From the next cycle, `empty_o` is 1 and the start bit is on the line.
- R5: `clr_empty_i` makes `empty_o` 0 in the next cycle. If a transfer happens in the same cycle, `empty_o` becomes 1 instead.
- R6: If a byte is waiting when a stop bit ends, the next start bit follows at once, with no idle cycle in between.
- R7: `end_o` becomes 1 in the cycle after a stop bit ends while `empty_o` is 1. `end_o` becomes 0 after a `wr_i` or a transfer, and a write in the same cycle as a stop bit ending wins.
- R8: While `tx_en_i` is 0, no new transfer starts, but a frame already on the line still completes.
- R9: `irq_empty_o` equals `tie_i` AND `empty_o`, and `irq_end_o` equals `teie_i` AND `end_o`.
- R10: After reset, `txd_o`=1, `empty_o`=1 and `end_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Baud tick pulse, TICKS_PER_BIT per bit |
| tx_en_i | input | 1 | Transmit enable |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to write |
| mpb_i | input | 1 | Address flag value for the next frame |
| clr_empty_i | input | 1 | Clears the empty flag (byte is valid) |
| tie_i | input | 1 | Empty interrupt enable |
| teie_i | input | 1 | End interrupt enable |
| txd_o | output | 1 | Serial line |
| empty_o | output | 1 | Holding register empty flag |
| end_o | output | 1 | Transmission ended flag |
| irq_empty_o | output | 1 | Empty interrupt request |
| irq_end_o | output | 1 | End interrupt request |

## Verification
The bench uses the default parameters: 8 data bits and 16 ticks per bit, so one frame is 176 ticks long. It runs one phase where a tick arrives every cycle and other phases where ticks are sparse or random. Random writes, clears and enable changes across thousands of cycles make a write, a clear or a change of `tx_en_i` coincide with the end of a stop bit. This reaches the back-to-back and flag-priority cases.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
    localparam int MPTX_DATA_W = 8;
    localparam int MPTX_TICKS  = 16;

    function automatic int frame_bits(input int data_w);
        return data_w + 3;
    endfunction
endpackage

// File: rtl/mptx_bit_timer.sv
module mptx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic bit_done_o
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign bit_done_o = run_i && tick_i && (st_q.cnt == CW'(TICKS - 1));

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (run_i && tick_i) begin
            st_d.cnt = bit_done_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mpb_i,
    input  logic              bit_done_i,
    output logic              busy_o,
    output logic              line_o,
    output logic              stop_done_o
);
    localparam int FRAME = mptx_pkg::frame_bits(DATA_W);
    localparam int IW    = $clog2(FRAME);

    typedef struct packed {
        logic [FRAME-1:0] sh;
        logic [IW-1:0]    idx;
        logic             busy;
    } shf_t;

    shf_t st_d, st_q;

    assign busy_o      = st_q.busy;
    assign line_o      = st_q.busy ? st_q.sh[0] : 1'b1;
    assign stop_done_o = bit_done_i && (st_q.idx == IW'(FRAME - 1));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh   = {1'b1, mpb_i, data_i, 1'b0};
            st_d.idx  = '0;
            st_d.busy = 1'b1;
        end else if (bit_done_i) begin
            if (stop_done_o) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.sh  = {1'b1, st_q.sh[FRAME-1:1]};
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '1, idx: '0, busy: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mptx_holdreg.sv
module mptx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_empty_i,
    input  logic              xfer_i,
    input  logic              stop_done_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o,
    output logic              end_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
        logic              tend;
    } hold_t;

    hold_t st_d, st_q;

    assign data_o  = st_q.data;
    assign empty_o = st_q.empty;
    assign end_o   = st_q.tend;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.data = wr_data_i;

        if (xfer_i)           st_d.empty = 1'b1;
        else if (clr_empty_i) st_d.empty = 1'b0;

        if (wr_i || xfer_i)                     st_d.tend = 1'b0;
        else if (stop_done_i && st_q.empty)     st_d.tend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{data: '0, empty: 1'b1, tend: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mptx_top.sv
module mptx_top #(
    parameter int DATA_W        = mptx_pkg::MPTX_DATA_W,
    parameter int TICKS_PER_BIT = mptx_pkg::MPTX_TICKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              tx_en_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              mpb_i,
    input  logic              clr_empty_i,
    input  logic              tie_i,
    input  logic              teie_i,
    output logic              txd_o,
    output logic              empty_o,
    output logic              end_o,
    output logic              irq_empty_o,
    output logic              irq_end_o
);
    logic              busy;
    logic              bit_done;
    logic              stop_done;
    logic              xfer;
    logic [DATA_W-1:0] hold_data;

    assign xfer = tx_en_i && !empty_o && (!busy || stop_done);

    mptx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (xfer),
        .run_i      (busy),
        .tick_i     (tick_i),
        .bit_done_o (bit_done)
    );

    mptx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (xfer),
        .data_i      (hold_data),
        .mpb_i       (mpb_i),
        .bit_done_i  (bit_done),
        .busy_o      (busy),
        .line_o      (txd_o),
        .stop_done_o (stop_done)
    );

    mptx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_i),
        .wr_data_i   (wr_data_i),
        .clr_empty_i (clr_empty_i),
        .xfer_i      (xfer),
        .stop_done_i (stop_done),
        .data_o      (hold_data),
        .empty_o     (empty_o),
        .end_o       (end_o)
    );

    assign irq_empty_o = tie_i && empty_o;
    assign irq_end_o   = teie_i && end_o;
endmodule

// File: rtl/mptx_checker.sv
module mptx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic wr_i,
    input logic txd_o,
    input logic empty_o,
    input logic end_o,
    input logic busy,
    input logic xfer,
    input logic stop_done
);
    // R1: line rests at mark while the shifter is idle
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd_o);

    // R2: line changes only on a tick while a frame is running
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_i) |=> $stable(txd_o));

    // R4: transfer only takes a valid byte and leaves the flag set
    a_r4_xfer_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> !empty_o);
    a_r4_empty_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> empty_o);

    // R7: end flag rules
    a_r7_end_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && empty_o && !wr_i) |=> end_o);
    a_r7_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !end_o);
endmodule

bind mptx_top mptx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_i      (wr_i),
    .txd_o     (txd_o),
    .empty_o   (empty_o),
    .end_o     (end_o),
    .busy      (busy),
    .xfer      (xfer),
    .stop_done (stop_done)
);

// File: tb/tb_mptx_top.sv
module tb_mptx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       tx_en_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       mpb_i = 1'b0;
    logic       clr_empty_i = 1'b0;
    logic       tie_i = 1'b0;
    logic       teie_i = 1'b0;
    logic       txd_o, empty_o, end_o, irq_empty_o, irq_end_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mptx_top dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tx_en_i(tx_en_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i), .mpb_i(mpb_i),
        .clr_empty_i(clr_empty_i), .tie_i(tie_i), .teie_i(teie_i),
        .txd_o(txd_o), .empty_o(empty_o), .end_o(end_o),
        .irq_empty_o(irq_empty_o), .irq_end_o(irq_end_o)
    );

    // reference model
    bit         line_q[$];
    int         tcnt = 0;
    bit         m_empty = 1'b1;
    bit         m_end = 1'b1;
    bit [7:0]   m_hold = '0;
    bit         m_b2b = 1'b0;
    bit         m_clr_seen = 1'b0;
    bit         m_held_off = 1'b0;

    always @(posedge clk) begin
        bit busy, bdone, sdone, xf, n_empty, n_end;
        if (!rst_n) begin
            line_q.delete();
            tcnt = 0; m_empty = 1; m_end = 1; m_hold = '0;
            m_b2b = 0; m_clr_seen = 0; m_held_off = 0;
        end else begin
            busy  = line_q.size() > 0;
            bdone = busy && tick_i && tcnt == 15;
            sdone = bdone && line_q.size() == 1;
            xf    = tx_en_i && !m_empty && (!busy || sdone);
            if (busy && tick_i) begin
                if (tcnt == 15) begin tcnt = 0; void'(line_q.pop_front()); end
                else tcnt++;
            end
            m_b2b = 0;
            if (xf) begin
                m_b2b = sdone;
                line_q.delete();
                line_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) line_q.push_back(m_hold[i]);
                line_q.push_back(mpb_i);
                line_q.push_back(1'b1);
                tcnt = 0;
            end
            n_empty = xf ? 1'b1 : (clr_empty_i ? 1'b0 : m_empty);
            n_end   = (wr_i || xf) ? 1'b0 : ((sdone && m_empty) ? 1'b1 : m_end);
            m_held_off = !tx_en_i && !m_empty && !busy;
            m_clr_seen = clr_empty_i && !xf;
            m_empty = n_empty;
            m_end   = n_end;
            if (wr_i) m_hold = wr_data_i;
        end
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // compare every cycle, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        cycles++;
        if (rst_n && !done) begin
            logic exp_txd;
            exp_txd = (line_q.size() > 0) ? line_q[0] : 1'b1;
            if (line_q.size() == 0)      check("R1", "txd idle", txd_o, exp_txd);
            else if (line_q.size() == 2) check("R3", "flag bit", txd_o, exp_txd);
            else if (m_b2b && line_q.size() == 11) check("R6", "back-to-back start", txd_o, exp_txd);
            else                         check("R2", "frame bit", txd_o, exp_txd);
            if (m_clr_seen)      check("R5", "empty after clear", empty_o, m_empty);
            else if (m_held_off) check("R8", "no transfer while disabled", empty_o, m_empty);
            else                 check("R4", "empty flag", empty_o, m_empty);
            check("R7", "end flag", end_o, m_end);
            check("R9", "empty irq", irq_empty_o, tie_i && m_empty);
            check("R9", "end irq", irq_end_o, teie_i && m_end);
        end
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(input bit tk);
        @(negedge clk);
        tick_i = tk; wr_i = 0; clr_empty_i = 0;
    endtask

    task automatic send(input logic [7:0] d, input logic mp);
        @(negedge clk);
        wr_i = 1; wr_data_i = d; clr_empty_i = 0; tick_i = 1;
        @(negedge clk);
        wr_i = 0; clr_empty_i = 1; mpb_i = mp;
        @(negedge clk);
        clr_empty_i = 0;
    endtask

    task automatic wait_empty(input int period);
        int n;
        n = 0;
        while (!empty_o && n < 20000) begin step((n % period) == 0); n++; end
    endtask

    task automatic wait_end(input int period);
        int n;
        n = 0;
        while (!end_o && n < 20000) begin step((n % period) == 0); n++; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10", "reset txd", txd_o, 1'b1);
        check("R10", "reset empty", empty_o, 1'b1);
        check("R10", "reset end", end_o, 1'b1);
        rst_n = 1;
        @(negedge clk);
        tie_i = 1; teie_i = 1; tx_en_i = 1;

        // single ID frame, tick every cycle
        send(8'hA5, 1'b1);
        wait_end(1);

        // two data frames back to back
        send(8'h3C, 1'b0);
        wait_empty(1);
        send(8'h5A, 1'b0);
        wait_end(1);

        // sparse ticks, alternating flags
        send(8'h81, 1'b1);
        wait_empty(3);
        send(8'h7E, 1'b0);
        wait_end(3);

        // disabled: byte waits, then goes once enabled
        tx_en_i = 0;
        send(8'hC3, 1'b1);
        for (int i = 0; i < 100; i++) step(1'b1);
        tx_en_i = 1;
        wait_end(1);

        // random stress
        teie_i = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            tick_i      = ($urandom % 4) != 0;
            wr_i        = ($urandom % 40) == 0;
            wr_data_i   = 8'($urandom);
            clr_empty_i = ($urandom % 30) == 0;
            mpb_i       = $urandom % 2;
            tx_en_i     = ($urandom % 50) != 0;
            tie_i       = $urandom % 2;
            teie_i      = $urandom % 2;
        end
        step(1'b0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule